// File: doc/BRIEF.md
# Burst-Limited FIFO Transfer Chunker

This block moves a block of bytes of any length into or out of a peripheral's data FIFO register by way of a separate transaction framer. The framer can carry at most 64 bytes per transaction, and the peripheral gives the number of bytes it will take or supply next as a burst count inside its 32-bit status word. The chunker cuts the block into pieces that satisfy both limits.

Before each piece the chunker issues a 4-byte status read through the framer and extracts the burst count. When the count is zero the peripheral is busy, so the status is read again. A parameter bounds how many consecutive zero reads are tolerated. Once the count is nonzero, the chunker issues one FIFO access whose length is the smallest of three values: the bytes still to move, the burst count, and 64. It repeats until the whole block has moved, then pulses done.

Payload bytes pass straight between the framer's byte channel and the buffer stream. Status bytes stay inside the block.

Top module: `fifo_chunker`

## Requirements
- R1: Every status read is a request with `req_read`=1, `req_addr`=0x18 and `req_len`=4. One such read precedes every FIFO access.
- R2: The four status bytes arrive least significant byte first. The burst count is bits 23:8 of the assembled word, and the byte at bits 31:24 has no effect on it.
- R3: A burst count of zero causes another status read and no FIFO access.
- R4: Each FIFO request has `req_addr`=0x24, `req_read` equal to the latched `dir` (1 means read from the FIFO), and `req_len` = min(bytes remaining, burst count, 64).
- R5: Status reads and chunks continue until the bytes moved equal `total_len`. `done` is then high for exactly one cycle with `err`=0.
- R6: A `start` with `total_len`=0 raises `done` on the next cycle and issues no request.
- R7: When `MAX_ZERO_READS` consecutive status reads return a zero burst count, the transfer ends with `done` and `err`=1 and makes no further request. Any nonzero read restarts this count.
- R8: For a FIFO read, each received byte appears on `buf_wr_data` with `buf_wr_valid` in the same cycle. For a FIFO write, each byte the framer takes is `buf_rd_data`, and `buf_rd_take` is pulsed with it. Status bytes never reach the buffer.
- R9: Once raised, `req_valid` stays high with stable address, length and direction until `req_ready`.
- R10: During and after reset, `busy`, `done` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| dir | input | 1 | 1 = read from the FIFO, 0 = write to it |
| total_len | input | LEN_W | Bytes to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero-burst retry limit hit; valid with done |
| req_valid | output | 1 | Framer request pending |
| req_ready | input | 1 | Framer accepts the request |
| req_read | output | 1 | Request direction, 1 = read |
| req_addr | output | ADDR_W | Register offset |
| req_len | output | CHUNK_W | Byte count of the request |
| fr_rd_valid | input | 1 | Framer delivers a received byte |
| fr_rd_data | input | 8 | Received byte |
| fr_wr_take | input | 1 | Framer consumes a byte to send |
| fr_wr_data | output | 8 | Byte to send |
| fr_end | input | 1 | Last byte of the current transaction |
| buf_wr_valid | output | 1 | Byte to store in the buffer |
| buf_wr_data | output | 8 | Byte to store |
| buf_rd_take | output | 1 | Advance the buffer read pointer |
| buf_rd_data | input | 8 | Current buffer byte |

## Verification
Two decisions can fall in the same cycle and need separate checks.

The first is the last byte of a chunk that also exhausts the remaining length. Completion must be chosen there instead of another status read. The sweep provokes this with lengths of exactly 64, 65, 130 and 200 against burst counts of 1, 5, 9, 70 and large values. It judges each case by comparing the observed chunk list and status read count with a bench model.

The second is a zero burst read that is also the last one the retry limit allows. Here the error end must be taken instead of a retry. An always-busy script is compared with a script that returns two zeros and then a nonzero count, which tells the limit case apart from one read short of it.

// File: rtl/chunker_pkg.sv
package chunker_pkg;

  localparam int STS_BYTES = 4;
  localparam int BURST_LSB = 8;
  localparam int BURST_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STS_REQ,
    ST_STS_DATA,
    ST_EVAL,
    ST_FIFO_REQ,
    ST_FIFO_XFER,
    ST_DONE
  } chunk_state_e;

  // Index, in arrival order, of the status byte holding burst byte b.
  function automatic int burst_byte_slot(int b);
    return BURST_LSB / 8 + b;
  endfunction

endpackage

// File: rtl/status_assembler.sv
module status_assembler
  import chunker_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  output logic [BURST_W-1:0]  burst
);

  localparam int IDX_W = $clog2(STS_BYTES);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx <= '0;
    else if (clear)    idx <= '0;
    else if (in_valid) idx <= idx + 1'b1;
  end

  for (genvar b = 0; b < BURST_W / 8; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        burst[8*b +: 8] <= '0;
      else if (in_valid && idx == IDX_W'(burst_byte_slot(b)))
        burst[8*b +: 8] <= in_data;
    end
  end

endmodule

// File: rtl/chunk_sizer.sv
module chunk_sizer #(
  parameter int LEN_W     = 16,
  parameter int BURST_W   = 16,
  parameter int FRAME_MAX = 64,
  parameter int CHUNK_W   = $clog2(FRAME_MAX + 1)
) (
  input  logic [LEN_W-1:0]   remaining,
  input  logic [BURST_W-1:0] burst,
  output logic [CHUNK_W-1:0] chunk,
  output logic               burst_zero
);

  function automatic logic [CHUNK_W-1:0] pick_chunk(
    input logic [LEN_W-1:0]   rem,
    input logic [BURST_W-1:0] bc
  );
    logic [31:0] m;
    m = (32'(rem) < 32'(bc)) ? 32'(rem) : 32'(bc);
    if (m > 32'(FRAME_MAX)) m = 32'(FRAME_MAX);
    return CHUNK_W'(m);
  endfunction

  assign chunk      = pick_chunk(remaining, burst);
  assign burst_zero = (burst == '0);

endmodule

// File: rtl/retry_tracker.sv
module retry_tracker #(
  parameter int MAX_ZERO_READS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic exhausted
);

  localparam int CNT_W = $clog2(MAX_ZERO_READS + 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (bump)  count <= count + 1'b1;
  end

  // The next zero read would be the last one allowed.
  assign exhausted = (count == CNT_W'(MAX_ZERO_READS - 1));

endmodule

// File: rtl/fifo_chunker.sv
module fifo_chunker
  import chunker_pkg::*;
#(
  parameter int              ADDR_W         = 16,
  parameter int              LEN_W          = 16,
  parameter int              FRAME_MAX      = 64,
  parameter int              MAX_ZERO_READS = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR     = 16'h0018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR    = 16'h0024,
  localparam int             CHUNK_W        = $clog2(FRAME_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir,
  input  logic [LEN_W-1:0]   total_len,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_read,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [CHUNK_W-1:0] req_len,
  input  logic               fr_rd_valid,
  input  logic [7:0]         fr_rd_data,
  input  logic               fr_wr_take,
  output logic [7:0]         fr_wr_data,
  input  logic               fr_end,
  output logic               buf_wr_valid,
  output logic [7:0]         buf_wr_data,
  output logic               buf_rd_take,
  input  logic [7:0]         buf_rd_data
);

  chunk_state_e       state;
  logic               dir_q;
  logic [LEN_W-1:0]   remaining;
  logic [CHUNK_W-1:0] chunk_q;
  logic [BURST_W-1:0] burst;
  logic [CHUNK_W-1:0] chunk;
  logic               burst_zero;
  logic               exhausted;

  // Named internal events, used by the FSM and the checker.
  logic sts_phase, fifo_phase, sts_done_ev, zero_read_ev, exhaust_ev;
  logic chunk_ev, chunk_done_ev, last_chunk_ev, launch_ev;

  assign sts_phase     = (state == ST_STS_DATA);
  assign fifo_phase    = (state == ST_FIFO_XFER);
  assign sts_done_ev   = sts_phase && fr_end;
  assign zero_read_ev  = (state == ST_EVAL) && burst_zero;
  assign exhaust_ev    = zero_read_ev && exhausted;
  assign chunk_ev      = (state == ST_EVAL) && !burst_zero;
  assign chunk_done_ev = fifo_phase && fr_end;
  assign last_chunk_ev = chunk_done_ev && (remaining == LEN_W'(chunk_q));
  assign launch_ev     = (state == ST_IDLE) && start;

  status_assembler u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (state == ST_STS_REQ),
    .in_valid (sts_phase && fr_rd_valid),
    .in_data  (fr_rd_data),
    .burst    (burst)
  );

  chunk_sizer #(
    .LEN_W     (LEN_W),
    .BURST_W   (BURST_W),
    .FRAME_MAX (FRAME_MAX),
    .CHUNK_W   (CHUNK_W)
  ) u_size (
    .remaining  (remaining),
    .burst      (burst),
    .chunk      (chunk),
    .burst_zero (burst_zero)
  );

  retry_tracker #(
    .MAX_ZERO_READS (MAX_ZERO_READS)
  ) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch_ev || chunk_ev),
    .bump      (zero_read_ev),
    .exhausted (exhausted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dir_q     <= 1'b0;
      remaining <= '0;
      chunk_q   <= '0;
      err       <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          dir_q     <= dir;
          remaining <= total_len;
          err       <= 1'b0;
          state     <= (total_len == '0) ? ST_DONE : ST_STS_REQ;
        end
        ST_STS_REQ:  if (req_ready) state <= ST_STS_DATA;
        ST_STS_DATA: if (fr_end)    state <= ST_EVAL;
        ST_EVAL: begin
          if (exhaust_ev) begin
            err   <= 1'b1;
            state <= ST_DONE;
          end else if (zero_read_ev) begin
            state <= ST_STS_REQ;
          end else begin
            chunk_q <= chunk;
            state   <= ST_FIFO_REQ;
          end
        end
        ST_FIFO_REQ: if (req_ready) state <= ST_FIFO_XFER;
        ST_FIFO_XFER: if (fr_end) begin
          remaining <= remaining - LEN_W'(chunk_q);
          state     <= last_chunk_ev ? ST_DONE : ST_STS_REQ;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = (state == ST_STS_REQ) || (state == ST_FIFO_REQ);
    if (state == ST_STS_REQ) begin
      req_read = 1'b1;
      req_addr = STS_ADDR;
      req_len  = CHUNK_W'(STS_BYTES);
    end else begin
      req_read = dir_q;
      req_addr = FIFO_ADDR;
      req_len  = chunk_q;
    end
  end

  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_DONE);
  assign buf_wr_valid = fifo_phase && dir_q && fr_rd_valid;
  assign buf_wr_data  = fr_rd_data;
  assign buf_rd_take  = fifo_phase && !dir_q && fr_wr_take;
  assign fr_wr_data   = buf_rd_data;

endmodule

// File: rtl/fifo_chunker_checker.sv
module fifo_chunker_checker #(
  parameter int              ADDR_W    = 16,
  parameter int              LEN_W     = 16,
  parameter int              CHUNK_W   = 7,
  parameter int              BURST_W   = 16,
  parameter int              FRAME_MAX = 64,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 16'h0018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 16'h0024
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic [LEN_W-1:0]   total_len,
  input logic               done,
  input logic               err,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_read,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [CHUNK_W-1:0] req_len,
  input logic [LEN_W-1:0]   remaining,
  input logic [BURST_W-1:0] burst,
  input logic [CHUNK_W-1:0] chunk,
  input logic               chunk_ev,
  input logic               zero_read_ev,
  input logic               exhaust_ev
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_read)); // R9

  AST_STS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr == STS_ADDR |-> req_read && req_len == CHUNK_W'(4)); // R1

  AST_CHUNK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr == FIFO_ADDR |-> req_len != '0 && req_len <= CHUNK_W'(FRAME_MAX)
      && LEN_W'(req_len) <= remaining); // R4

  AST_CHUNK_WITHIN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_ev |-> BURST_W'(chunk) <= burst && chunk != '0); // R2

  AST_RETRY_REREAD: assert property (@(posedge clk) disable iff (!rst_n)
    zero_read_ev && !exhaust_ev |=> req_valid && req_addr == STS_ADDR); // R3

  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && total_len == '0 |=> done && !req_valid); // R6

  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R7

  AST_EXHAUST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_ev |=> done && err && !req_valid); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R5

endmodule

bind fifo_chunker fifo_chunker_checker #(
  .ADDR_W    (ADDR_W),
  .LEN_W     (LEN_W),
  .CHUNK_W   (CHUNK_W),
  .BURST_W   (chunker_pkg::BURST_W),
  .FRAME_MAX (FRAME_MAX),
  .STS_ADDR  (STS_ADDR),
  .FIFO_ADDR (FIFO_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .total_len    (total_len),
  .done         (done),
  .err          (err),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_read     (req_read),
  .req_addr     (req_addr),
  .req_len      (req_len),
  .remaining    (remaining),
  .burst        (burst),
  .chunk        (chunk),
  .chunk_ev     (chunk_ev),
  .zero_read_ev (zero_read_ev),
  .exhaust_ev   (exhaust_ev)
);

// File: tb/test_fifo_chunker.sv
`timescale 1ns/1ps
module test_fifo_chunker;

  localparam int MAXZ = 3;
  localparam logic [15:0] STS  = 16'h0018;
  localparam logic [15:0] FIFO = 16'h0024;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0, dir = 1'b0;
  logic [15:0] total_len = '0;
  logic        busy, done, err;
  logic        req_valid, req_read;
  logic        req_ready = 1'b0;
  logic [15:0] req_addr;
  logic [6:0]  req_len;
  logic        fr_rd_valid = 1'b0, fr_wr_take = 1'b0, fr_end = 1'b0;
  logic [7:0]  fr_rd_data = '0;
  logic [7:0]  fr_wr_data;
  logic        buf_wr_valid, buf_rd_take;
  logic [7:0]  buf_wr_data, buf_rd_data;

  fifo_chunker #(.MAX_ZERO_READS(MAXZ)) i_fifo_chunker (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .total_len(total_len),
    .busy(busy), .done(done), .err(err),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_addr(req_addr), .req_len(req_len),
    .fr_rd_valid(fr_rd_valid), .fr_rd_data(fr_rd_data), .fr_wr_take(fr_wr_take),
    .fr_wr_data(fr_wr_data), .fr_end(fr_end),
    .buf_wr_valid(buf_wr_valid), .buf_wr_data(buf_wr_data),
    .buf_rd_take(buf_rd_take), .buf_rd_data(buf_rd_data)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_pat(input int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  function automatic logic [7:0] tx_pat(input int i);
    return 8'((i * 13 + 91) ^ (i >> 2));
  endfunction

  // Burst count scripts, indexed by status read number within a job.
  function automatic logic [15:0] get_burst(input int s, input int i);
    case (s)
      0: return 16'h0100;
      1: case (i % 4) 0: return 16'd0; 1: return 16'd5; 2: return 16'd70; default: return 16'd1; endcase
      2: return 16'd0;
      3: return (i % 3 == 2) ? 16'd9 : 16'd0;
      default: return 16'h8003;
    endcase
  endfunction

  // Job configuration (written only by the main sequence).
  int cur_script = 0, sts_base = 0, ready_delay = 0;
  logic exp_dir = 1'b0;

  // Framer and buffer observations (cumulative, written by one process each).
  int obs_len [256];
  int n_obs = 0, n_sts = 0, data_err = 0, hold_err = 0, addr_err = 0;
  int rx_idx = 0, wr_k = 0, tx_idx = 0;

  assign buf_rd_data = tx_pat(tx_idx);

  initial begin
    forever begin
      @(posedge clk);
      if (buf_rd_take) tx_idx <= tx_idx + 1;
    end
  end

  // Framer model.
  initial begin
    logic [15:0] a;
    logic [6:0]  l;
    logic        r;
    logic [31:0] sts_w;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        a = req_addr; l = req_len; r = req_read;
        for (int d = 0; d < ready_delay; d++) begin
          @(negedge clk);
          if (!req_valid || req_addr != a || req_len != l || req_read != r) hold_err++;
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        sts_w = '0;
        if (a == STS) begin
          if (!r || l != 7'd4) addr_err++;
          sts_w = {8'hC3, get_burst(cur_script, n_sts - sts_base), 8'h5A};
          n_sts++;
        end else if (a == FIFO) begin
          obs_len[n_obs % 256] = int'(l);
          n_obs++;
          if (r != exp_dir) addr_err++;
        end else addr_err++;
        for (int k = 0; k < int'(l); k++) begin
          if (r) begin
            fr_rd_valid = 1'b1;
            fr_rd_data  = (a == STS) ? sts_w[8*k +: 8] : rd_pat(rx_idx);
          end else fr_wr_take = 1'b1;
          fr_end = (k == int'(l) - 1);
          #1;
          if (r) begin
            if (a == STS) begin
              if (buf_wr_valid) data_err++;
            end else begin
              if (!buf_wr_valid || buf_wr_data != rd_pat(rx_idx)) data_err++;
              rx_idx++;
            end
          end else begin
            if (buf_rd_take !== 1'b1 || fr_wr_data != tx_pat(wr_k)) data_err++;
            wr_k++;
          end
          @(negedge clk);
        end
        fr_rd_valid = 1'b0; fr_wr_take = 1'b0; fr_end = 1'b0;
      end
    end
  end

  task automatic run_job(input int s, input logic d, input int len, input int dly);
    int exp_len [256];
    int n_exp = 0, exp_sts = 0, zeros = 0, rem, b, c, moved = 0, cyc = 0;
    bit exp_err = 0;
    int obs0, sts0, derr0, herr0, aerr0, rx0, tx0;
    string tag;
    rem = len;
    while (rem > 0) begin
      b = int'(get_burst(s, exp_sts));
      exp_sts++;
      if (b == 0) begin
        zeros++;
        if (zeros == MAXZ) begin exp_err = 1; break; end
        continue;
      end
      zeros = 0;
      c = (rem < b) ? rem : b;
      if (c > 64) c = 64;
      exp_len[n_exp] = c; n_exp++;
      rem -= c; moved += c;
    end
    tag = $sformatf("s%0d d%0d len%0d", s, d, len);

    @(negedge clk);
    cur_script = s; exp_dir = d; ready_delay = dly; sts_base = n_sts;
    obs0 = n_obs; sts0 = n_sts; derr0 = data_err; herr0 = hold_err;
    aerr0 = addr_err; rx0 = rx_idx; tx0 = tx_idx;
    start = 1'b1; dir = d; total_len = 16'(len);
    @(negedge clk);
    start = 1'b0;
    if (len == 0)
      chk(done === 1'b1 && !req_valid, "R6", {tag, " done next cycle"}, int'(done), 1);
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R5", {tag, " done seen"}, int'(done), 1);
    chk(err === exp_err, "R7", {tag, " err"}, int'(err), int'(exp_err));
    @(negedge clk);
    chk(!done && !busy, "R5", {tag, " done one cycle"}, int'(done), 0);
    chk(n_sts - sts0 == exp_sts, "R3", {tag, " status reads"}, n_sts - sts0, exp_sts);
    chk(n_obs - obs0 == n_exp, "R4", {tag, " chunk count"}, n_obs - obs0, n_exp);
    for (int i = 0; i < n_exp && i < n_obs - obs0; i++)
      chk(obs_len[(obs0 + i) % 256] == exp_len[i], "R4", {tag, $sformatf(" chunk %0d", i)},
          obs_len[(obs0 + i) % 256], exp_len[i]);
    chk(addr_err == aerr0, "R1", {tag, " request shape"}, addr_err - aerr0, 0);
    chk(data_err == derr0, "R8", {tag, " data path"}, data_err - derr0, 0);
    chk(hold_err == herr0, "R9", {tag, " request hold"}, hold_err - herr0, 0);
    if (d) chk(rx_idx - rx0 == moved, "R8", {tag, " bytes read"}, rx_idx - rx0, moved);
    else   chk(tx_idx - tx0 == moved, "R8", {tag, " bytes written"}, tx_idx - tx0, moved);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R5 watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lens [7] = '{0, 1, 3, 64, 65, 130, 200};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_valid, "R10", "in reset", int'(busy | done | req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !req_valid, "R10", "after reset", int'(busy | done | req_valid), 0);
    for (int s = 0; s < 5; s++)
      for (int d = 0; d < 2; d++)
        for (int j = 0; j < 7; j++)
          run_job(s, d[0], lens[j], (s + j) % 3);
    // R2: high-byte garbage and byte order checked via script 1 and 4 results above.
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule